// File: doc/BRIEF.md
# Masked Vector Gather/Scatter Sequencer

This block turns one vector memory operation into a series of scalar memory accesses. It takes a 64-bit scalar base, sixteen 32-bit signed lane indices, a two-bit scale code, a sixteen-bit lane enable mask and an operation select. For each enabled lane it computes an address, then issues one scalar access on a simple request/acknowledge port. A gather reads memory. A scatter writes that lane's source word. Only one access is outstanding at any time.

Read data lands in the matching lane of a destination vector register that persists between operations. Lanes whose enable bit is clear keep what they held before. Lanes are visited in ascending order. Two lanes with the same index therefore read the same word (a partial broadcast), and in a scatter the higher lane's write is the one left in memory. A one-cycle `done` pulse marks the end of every accepted operation. This includes an operation with an empty mask, which makes no access at all.

Top module: `vgather_seq`

## Requirements
- R1: The address of lane i is `base + (sext64(index[i]) << s)`, where the index is taken as a signed 32-bit value and s comes from the scale code: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives 2 and 2'b11 gives 3. The sum wraps modulo 2^64.
- R2: An operation makes exactly one memory access for each lane whose `wmask` bit is 1 and no access for any other lane. Lane i uses bits [32*i+31:32*i] of `index_vec`, `src_vec` and `dst_vec`.
- R3: Enabled lanes are accessed in ascending lane order, lowest first.
- R4: In a gather, each enabled lane of `dst_vec` takes the `mem_rdata` of its own access. Disabled lanes keep their previous contents, and a scatter leaves `dst_vec` unchanged.
- R5: In a scatter (`is_scatter`=1), every access has `mem_we`=1 and carries the lane's `src_vec` word on `mem_wdata`. Because lanes go in ascending order, the highest enabled lane wins when addresses collide. In a gather, `mem_we`=0.
- R6: Lanes with equal indices in a gather all receive the same memory word.
- R7: When `wmask` is all zeros, `done` is high in the cycle after `start` is taken and `mem_req` never rises.
- R8: `done` is high for exactly one cycle, the cycle after the last enabled lane's acknowledge is taken. `busy` is high from the cycle after `start` until that point.
- R9: `start` is ignored while `busy` is high. A `start` in the same cycle as `done` is accepted.
- R10: After reset, `mem_req`, `done` and `busy` are low and `dst_vec` is all zeros.
- R11: Once raised, `mem_req` stays high with a stable `mem_addr` until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (taken when not busy) |
| is_scatter | input | 1 | 1 = scatter (write), 0 = gather (read) |
| base | input | 64 | Scalar base address |
| index_vec | input | 512 | Sixteen signed 32-bit lane indices |
| scale | input | 2 | Index scale code (x1, x2, x4, x8) |
| wmask | input | 16 | Lane enable mask |
| src_vec | input | 512 | Scatter source data, one word per lane |
| dst_vec | output | 512 | Gather destination register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 64 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted (read data valid) |
| mem_rdata | input | 32 | Read data |

## Verification
Two events can fall in the same cycle: the completion of one operation (the `done` pulse) and the acceptance of the next `start`. The bench raises `start` with a new base and mask in exactly the cycle where `done` is observed. It then checks that the second operation makes its full, correctly addressed access sequence and ends with its own pulse at the right cycle. The opposite case is also covered: a `start` with an empty mask sent while an operation is running must leave that run's access count, timing and results untouched.

// File: rtl/gseq_pkg.sv
package gseq_pkg;
   typedef enum logic [1:0] {
      SC_X1 = 2'b00,
      SC_X2 = 2'b01,
      SC_X4 = 2'b10,
      SC_X8 = 2'b11
   } gseq_scale_e;

   typedef enum logic {
      OP_GATHER  = 1'b0,
      OP_SCATTER = 1'b1
   } gseq_op_e;
endpackage

// File: rtl/gseq_addr_gen.sv
module gseq_addr_gen #(
   parameter int AW = 64,
   parameter int IW = 32
) (
   input  logic [AW-1:0]             base_i,
   input  logic [IW-1:0]             idx_i,
   input  gseq_pkg::gseq_scale_e     scale_i,
   output logic [AW-1:0]             addr_o
);
   logic [AW-1:0] sext;
   logic [AW-1:0] scaled;

   generate
      if (IW > AW) begin : g_bad_width
         $error("gseq_addr_gen: index wider than address");
      end else if (IW == AW) begin : g_same
         assign sext = idx_i;
      end else begin : g_extend
         assign sext = {{(AW-IW){idx_i[IW-1]}}, idx_i};
      end
   endgenerate

   always_comb begin
      scaled = sext << scale_i;
      addr_o = base_i + scaled;
   end
endmodule

// File: rtl/gseq_lane_pick.sv
module gseq_lane_pick #(
   parameter int LANES = 16,
   localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic [LANES-1:0] pending_i,
   output logic [LANES-1:0] grant_o,
   output logic [LW-1:0]    lane_o
);
   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("gseq_lane_pick: LANES must be at least 1");
      end
   endgenerate

   always_comb begin
      grant_o = pending_i & (~pending_i + {{(LANES-1){1'b0}}, 1'b1});
      lane_o  = '0;
      for (int i = LANES - 1; i >= 0; i--) begin
         if (pending_i[i]) lane_o = LW'(i);
      end
   end
endmodule

// File: rtl/gseq_lane_regs.sv
module gseq_lane_regs #(
   parameter int LANES = 16,
   parameter int DW    = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [LANES-1:0]    we_i,
   input  logic [DW-1:0]       wdata_i,
   output logic [LANES*DW-1:0] vec_o
);
   genvar g;
   generate
      for (g = 0; g < LANES; g++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       vec_o[g*DW +: DW] <= '0;
            else if (we_i[g]) vec_o[g*DW +: DW] <= wdata_i;
         end
      end
   endgenerate

   // R3
   one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(we_i));
endmodule

// File: rtl/vgather_seq.sv
module vgather_seq #(
   parameter int LANES = 16,
   parameter int DW    = 32,
   parameter int AW    = 64,
   parameter int IW    = 32,
   localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                is_scatter,
   input  logic [AW-1:0]       base,
   input  logic [LANES*IW-1:0] index_vec,
   input  logic [1:0]          scale,
   input  logic [LANES-1:0]    wmask,
   input  logic [LANES*DW-1:0] src_vec,
   output logic [LANES*DW-1:0] dst_vec,
   output logic                busy,
   output logic                done,
   output logic                mem_req,
   output logic                mem_we,
   output logic [AW-1:0]       mem_addr,
   output logic [DW-1:0]       mem_wdata,
   input  logic                mem_ack,
   input  logic [DW-1:0]       mem_rdata
);
   import gseq_pkg::*;

   generate
      if (IW > AW) begin : g_bad_idx
         $error("vgather_seq: IW must not exceed AW");
      end
   endgenerate

   logic                busy_q, done_q;
   logic [LANES-1:0]    pending_q;
   logic [AW-1:0]       base_q;
   logic [LANES*IW-1:0] idx_q;
   logic [LANES*DW-1:0] src_q;
   gseq_scale_e         scale_q;
   gseq_op_e            op_q;

   logic [LANES-1:0]    grant;
   logic [LW-1:0]       lane;
   logic [LANES-1:0]    pend_next;
   logic [LANES-1:0]    lane_we;
   logic                take;

   gseq_lane_pick #(.LANES(LANES)) u_pick (
      .pending_i (pending_q),
      .grant_o   (grant),
      .lane_o    (lane)
   );

   gseq_addr_gen #(.AW(AW), .IW(IW)) u_addr (
      .base_i  (base_q),
      .idx_i   (idx_q[lane*IW +: IW]),
      .scale_i (scale_q),
      .addr_o  (mem_addr)
   );

   gseq_lane_regs #(.LANES(LANES), .DW(DW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (lane_we),
      .wdata_i (mem_rdata),
      .vec_o   (dst_vec)
   );

   always_comb begin
      take      = busy_q & mem_ack;
      pend_next = pending_q & ~grant;
      lane_we   = (take && op_q == OP_GATHER) ? grant : '0;
      mem_req   = busy_q;
      mem_we    = busy_q & (op_q == OP_SCATTER);
      mem_wdata = src_q[lane*DW +: DW];
      busy      = busy_q;
      done      = done_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         pending_q <= '0;
         base_q    <= '0;
         idx_q     <= '0;
         src_q     <= '0;
         scale_q   <= SC_X1;
         op_q      <= OP_GATHER;
      end else begin
         done_q <= 1'b0;
         if (!busy_q && start) begin
            pending_q <= wmask;
            base_q    <= base;
            idx_q     <= index_vec;
            src_q     <= src_vec;
            scale_q   <= gseq_scale_e'(scale);
            op_q      <= gseq_op_e'(is_scatter);
            busy_q    <= |wmask;
            done_q    <= ~|wmask;
         end else if (take) begin
            pending_q <= pend_next;
            if (pend_next == '0) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   // R7
   empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && wmask == '0) |=> (done && !mem_req));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !$past(start)) |-> $past(mem_ack));

   // R9
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mem_ack) |=> (busy && $stable(pending_q)));
endmodule

// File: tb/vgather_seq_bench.sv
module vgather_seq_bench;
   localparam int L = 16;
   localparam int NV = 6;
   localparam logic [63:0] V_BASE [NV] = '{64'h1000, 64'h1_0000_0000, 64'h2000,
                                           64'hFFFF_FFFF_0000_0000, 64'h4000, 64'h8000};
   localparam int          V_PAT  [NV] = '{0, 1, 2, 5, 4, 3};
   localparam logic [1:0]  V_SC   [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b10, 2'b11};
   localparam logic [15:0] V_MASK [NV] = '{16'hFFFF, 16'hA5C3, 16'h0F0F, 16'h8001, 16'hFFFF, 16'h1234};
   localparam bit          V_SCT  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic          rst_n, start, is_scatter, busy, done, mem_req, mem_we, mem_ack;
   logic [63:0]   base, mem_addr;
   logic [511:0]  index_vec, src_vec, dst_vec;
   logic [1:0]    scale;
   logic [15:0]   wmask;
   logic [31:0]   mem_wdata, mem_rdata;

   vgather_seq u_vgather_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .is_scatter(is_scatter), .base(base),
      .index_vec(index_vec), .scale(scale), .wmask(wmask), .src_vec(src_vec),
      .dst_vec(dst_vec), .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   int checks = 0, fails = 0, cyc = 0;
   int wait_cnt = 0, lat_seed = 0, acc_n = 0, exp_n = 0, req_cycles = 0, last_ack_edge = 0;
   logic [63:0] exp_a [L];
   logic [31:0] exp_d [L];
   logic        exp_we;
   logic [31:0] model_dst [L];
   logic [31:0] store [logic [63:0]];
   logic [31:0] exp_st [logic [63:0]];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rd_word(input logic [63:0] a);
      if (store.exists(a)) return store[a];
      return a[31:0] ^ a[63:32] ^ 32'h5A5A_0000;
   endfunction

   function automatic logic [31:0] pat_idx(input int p, input int l);
      case (p)
         0: return 32'(l * 4);
         1: return 32'(-(l * 3) - 1);
         2: return 32'd5;
         3: return 32'(l * l - 20);
         4: return 32'(l >> 1);
         default: return 32'h7FFF_FFF0 + 32'(l);
      endcase
   endfunction

   // memory model: acknowledges with a latency of 0..2 cycles
   always @(negedge clk) begin
      mem_ack = 1'b0;
      if (mem_req) begin
         req_cycles++;
         if (wait_cnt == 0) begin
            mem_ack   = 1'b1;
            mem_rdata = rd_word(mem_addr);
            if (acc_n < exp_n) begin
               chk(mem_addr == exp_a[acc_n], "R1/R3 address", mem_addr, exp_a[acc_n]);
               chk(mem_we == exp_we, "R5 write enable", 64'(mem_we), 64'(exp_we));
               if (exp_we) chk(mem_wdata == exp_d[acc_n], "R5 write data", 64'(mem_wdata), 64'(exp_d[acc_n]));
            end else begin
               chk(1'b0, "R2 extra access", mem_addr, 64'h0);
            end
            if (mem_we) store[mem_addr] = mem_wdata;
            acc_n++;
            last_ack_edge = cyc + 1;
            lat_seed++;
            wait_cnt = lat_seed % 3;
         end else begin
            wait_cnt--;
         end
      end
   end

   // drive operands and build the expected model (inputs stay stable until the next prep)
   task automatic prep(input logic [63:0] b, input int p, input logic [1:0] sc,
                       input logic [15:0] m, input bit sct, input int vi);
      base = b; scale = sc; wmask = m; is_scatter = sct;
      exp_n = 0; acc_n = 0; req_cycles = 0; exp_we = sct;
      exp_st.delete();
      for (int l = 0; l < L; l++) begin
         logic [31:0] ix;
         logic [63:0] a;
         ix = pat_idx(p, l);
         index_vec[l*32 +: 32] = ix;
         src_vec[l*32 +: 32]   = 32'hC0DE_0000 + 32'(vi * 16 + l);
         a = b + ({{32{ix[31]}}, ix} << sc);
         if (m[l]) begin
            exp_a[exp_n] = a;
            exp_d[exp_n] = src_vec[l*32 +: 32];
            exp_n++;
            if (sct) exp_st[a] = src_vec[l*32 +: 32];
            else     model_dst[l] = rd_word(a);
         end
      end
   endtask

   task automatic wait_done(input int st_edge, input logic [15:0] m, input bit sct);
      int t;
      t = 0;
      while (!done && t < 2000) begin @(negedge clk); t++; end
      chk(done, "R8 done seen", 64'(done), 64'h1);
      if (m == 16'h0) begin
         chk(cyc == st_edge, "R7 empty-mask done timing", 64'(cyc), 64'(st_edge));
         chk(req_cycles == 0, "R7 no request", 64'(req_cycles), 64'h0);
      end else begin
         chk(cyc == last_ack_edge, "R8 done timing", 64'(cyc), 64'(last_ack_edge));
      end
      chk(acc_n == $countones(m), "R2 access count", 64'(acc_n), 64'($countones(m)));
      chk(!busy, "R8 busy clear at done", 64'(busy), 64'h0);
      for (int l = 0; l < L; l++)
         chk(dst_vec[l*32 +: 32] == model_dst[l], sct ? "R4 dst kept on scatter" : "R4/R6 dst lane",
             64'(dst_vec[l*32 +: 32]), 64'(model_dst[l]));
      foreach (exp_st[a])
         chk(store.exists(a) && store[a] == exp_st[a], "R5 scatter final value",
             store.exists(a) ? 64'(store[a]) : 64'hDEAD, 64'(exp_st[a]));
   endtask

   task automatic run_op(input logic [63:0] b, input int p, input logic [1:0] sc,
                         input logic [15:0] m, input bit sct, input int vi, input bit poke);
      int st_edge;
      @(negedge clk);
      prep(b, p, sc, m, sct, vi);
      start = 1'b1;
      st_edge = cyc + 1;
      @(negedge clk);
      start = 1'b0;
      if (poke && busy && !done) begin
         wmask = 16'h0;          // R9: start while busy must be ignored
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         wmask = m;
      end
      wait_done(st_edge, m, sct);
      @(negedge clk);
      chk(!done, "R8 done one cycle", 64'(done), 64'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int st_edge;
      rst_n = 1'b0; start = 1'b0; mem_ack = 1'b0; mem_rdata = '0;
      base = '0; index_vec = '0; src_vec = '0; scale = '0; wmask = '0; is_scatter = 1'b0;
      for (int l = 0; l < L; l++) model_dst[l] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10
      chk(!mem_req && !done && !busy, "R10 reset outputs", {61'h0, mem_req, done, busy}, 64'h0);
      chk(dst_vec == '0, "R10 reset dst", dst_vec[63:0], 64'h0);

      for (int v = 0; v < NV; v++)
         run_op(V_BASE[v], V_PAT[v], V_SC[v], V_MASK[v], V_SCT[v], v, v == 1);

      // R5/R6: gather back the colliding scatter region; each pair shows the higher lane's word
      run_op(64'h4000, 4, 2'b10, 16'hFFFF, 1'b0, 7, 1'b0);
      chk(dst_vec[0 +: 32] == 32'hC0DE_0000 + 32'(4 * 16 + 1), "R5 higher lane wins",
          64'(dst_vec[0 +: 32]), 64'(32'hC0DE_0000 + 32'(4 * 16 + 1)));

      // R7: empty mask
      run_op(64'h9000, 0, 2'b00, 16'h0000, 1'b0, 8, 1'b0);

      // R9: new start in the done cycle
      @(negedge clk);
      prep(64'hA000, 3, 2'b01, 16'h00F0, 1'b0, 9);
      start = 1'b1;
      st_edge = cyc + 1;
      @(negedge clk);
      start = 1'b0;
      while (!done && cyc < st_edge + 100) @(negedge clk);
      chk(done, "R9 first op done", 64'(done), 64'h1);
      prep(64'hB000, 1, 2'b11, 16'h8421, 1'b0, 10);
      start = 1'b1;
      st_edge = cyc + 1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R9 start in done cycle accepted", 64'(busy), 64'h1);
      wait_done(st_edge, 16'h8421, 1'b0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule